// File: doc/BRIEF.md
# Multi-Master Doorbell Unit

A bank of doorbells that lets any of up to 32 requesters on a shared register fabric notify a target processor. Every doorbell owns a 0x100-byte register window. A requester rings a doorbell by writing a one into the window's trigger register. The fabric attaches the requester's master number to each access, and that number selects the bit the ring affects. The target decides which requesters may interrupt it through a per-doorbell mask of allowed senders.

Every ring is recorded twice. An unfiltered record shows all rings, whether they were allowed or not. A filtered pending record holds only the allowed rings, and the doorbell's level interrupt stays high while that record is non-zero. Software on the target reads the pending vector, handles each sender and writes the same value back to clear it. The block has several register ports, so two requesters can act in the same clock. A ring that arrives in the same cycle as a clear of the same bit is never lost.

Top module: `mm_doorbell_bank`

## Requirements
- R1: Doorbell d decodes at base address d*0x100. Inside a window, byte offset 0x0 selects trigger, 0x4 selects the sender-enable mask, 0x8 selects the raw record and 0xC selects pending. Any other offset, and any window at or above NUM_DB, is ignored on writes and reads as zero.
- R2: A trigger write whose data bit 0 is one sets bit m of the raw record, where m is the master number on that port, whether or not enable bit m is set.
- R3: The same ring sets pending bit m only when enable bit m was set before that cycle.
- R4: The enable mask resets to zero and reads back what was last written. When two ports write the same doorbell's enable in the same cycle, the higher-numbered port's value is kept.
- R5: Pending is write-one-to-clear. Data bits that are zero leave the matching pending bits unchanged.
- R6: The raw record is write-one-to-clear in the same way.
- R7: When a ring and a clear hit the same bit in the same cycle, the bit ends up set. Other bits in the clear mask are still cleared.
- R8: A trigger write with data bit 0 equal to zero has no effect. A master number at or above NUM_MASTERS has no effect.
- R9: db_irq[d] is high exactly while any pending bit of doorbell d is set. It reflects a register change in the cycle after the write.
- R10: A read request returns rsp_valid and rsp_rdata on the same port one cycle later, and rsp_valid is low otherwise. The trigger register reads as zero.
- R11: After reset, all enable, raw and pending bits are zero and every interrupt is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | NUM_PORTS | Request strobe, one per port |
| bus_write | input | NUM_PORTS | 1 = write, 0 = read, per port |
| bus_addr | input | NUM_PORTS*ADDR_W | Byte address, port p at slice p*ADDR_W |
| bus_wdata | input | NUM_PORTS*32 | Write data, port p at slice p*32 |
| bus_mid | input | NUM_PORTS*MID_W | Master number of the requester on each port |
| rsp_valid | output | NUM_PORTS | Read data valid, one cycle after a read |
| rsp_rdata | output | NUM_PORTS*32 | Read data, port p at slice p*32 |
| db_irq | output | NUM_DB | Level interrupt, one per doorbell |

## Verification
The embedded assertions check four rules on every cycle. A ring always lands in the raw record. Pending bits rise only for senders that were enabled. An enabled ring survives a same-cycle clear. Cleared bits fall unless they are rung again. The assertions also check that interrupts rise only after a ring and that read responses keep their one-cycle timing. Other behaviours only the directed scenarios can show: the address decode with its ignored windows and offsets, enable read-back and port priority, the lack of effect of a zero trigger or an out-of-range master number, and the exact register values after mixed sequences.

// File: rtl/mm_doorbell_pkg.sv
package mm_doorbell_pkg;
   localparam int WORD_W = 32;

   typedef enum logic [1:0] {
      REG_RING  = 2'd0,
      REG_ALLOW = 2'd1,
      REG_SEEN  = 2'd2,
      REG_PEND  = 2'd3
   } db_reg_e;

   function automatic db_reg_e reg_of_addr(input logic [3:2] a);
      return db_reg_e'(a);
   endfunction
endpackage

// File: rtl/db_port_decode.sv
module db_port_decode
   import mm_doorbell_pkg::*;
#(
   parameter int NUM_DB      = 4,
   parameter int NUM_MASTERS = 32,
   parameter int ADDR_W      = 12,
   parameter int MID_W       = 6
) (
   input  logic                   req_valid,
   input  logic                   req_write,
   input  logic [ADDR_W-1:0]      req_addr,
   input  logic                   req_ring_bit,
   input  logic [MID_W-1:0]       req_mid,
   output logic [NUM_DB-1:0]      win_hit,
   output db_reg_e                reg_sel,
   output logic                   is_rd,
   output logic [NUM_MASTERS-1:0] ring_oh
);
   localparam int IDX_W = ADDR_W - 8;

   logic [IDX_W-1:0] win_idx;
   logic             offs_ok;

   assign win_idx = req_addr[ADDR_W-1:8];
   assign offs_ok = (req_addr[7:4] == 4'd0) && (req_addr[1:0] == 2'd0);
   assign reg_sel = reg_of_addr(req_addr[3:2]);
   assign is_rd   = req_valid && !req_write;

   always_comb begin
      for (int d = 0; d < NUM_DB; d++) begin
         win_hit[d] = req_valid && offs_ok && (win_idx == IDX_W'(d));
      end
   end

   always_comb begin
      for (int m = 0; m < NUM_MASTERS; m++) begin
         ring_oh[m] = req_valid && req_write && offs_ok && (reg_sel == REG_RING)
                      && req_ring_bit && (req_mid == MID_W'(m));
      end
   end
endmodule

// File: rtl/db_cell.sv
module db_cell #(
   parameter int NUM_MASTERS = 32
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NUM_MASTERS-1:0] ring_set,
   input  logic                   allow_we,
   input  logic [NUM_MASTERS-1:0] allow_wdata,
   input  logic [NUM_MASTERS-1:0] seen_clr,
   input  logic [NUM_MASTERS-1:0] pend_clr,
   output logic [NUM_MASTERS-1:0] allow_q,
   output logic [NUM_MASTERS-1:0] seen_q,
   output logic [NUM_MASTERS-1:0] pend_q
);
   logic [NUM_MASTERS-1:0] allowed_ring;

   assign allowed_ring = ring_set & allow_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         allow_q <= '0;
         seen_q  <= '0;
         pend_q  <= '0;
      end else begin
         if (allow_we) allow_q <= allow_wdata;
         seen_q <= (seen_q & ~seen_clr) | ring_set;
         pend_q <= (pend_q & ~pend_clr) | allowed_ring;
      end
   end

   assert_seen_on_ring_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (|ring_set) |=> ((seen_q & $past(ring_set)) == $past(ring_set)));

   assert_pend_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (|pend_q) |-> ((pend_q & ~$past(pend_q) & ~$past(allow_q)) == '0));

   assert_ring_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (|(ring_set & allow_q)) |=> ((pend_q & $past(ring_set & allow_q)) == $past(ring_set & allow_q)));

   assert_pend_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (|pend_clr) |=> ((pend_q & $past(pend_clr & ~(ring_set & allow_q))) == '0));
endmodule

// File: rtl/db_port_read.sv
module db_port_read
   import mm_doorbell_pkg::*;
#(
   parameter int NUM_DB      = 4,
   parameter int NUM_MASTERS = 32
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               rd_req,
   input  logic [NUM_DB-1:0]                  win_hit,
   input  db_reg_e                            reg_sel,
   input  logic [NUM_DB-1:0][NUM_MASTERS-1:0] allow_all,
   input  logic [NUM_DB-1:0][NUM_MASTERS-1:0] seen_all,
   input  logic [NUM_DB-1:0][NUM_MASTERS-1:0] pend_all,
   output logic                               rsp_valid,
   output logic [WORD_W-1:0]                  rsp_rdata
);
   logic [WORD_W-1:0] rd_word;

   always_comb begin
      rd_word = '0;
      for (int d = 0; d < NUM_DB; d++) begin
         if (win_hit[d]) begin
            unique case (reg_sel)
               REG_ALLOW: rd_word[NUM_MASTERS-1:0] = allow_all[d];
               REG_SEEN:  rd_word[NUM_MASTERS-1:0] = seen_all[d];
               REG_PEND:  rd_word[NUM_MASTERS-1:0] = pend_all[d];
               default:   rd_word = '0;
            endcase
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= rd_req;
         rsp_rdata <= rd_req ? rd_word : '0;
      end
   end

   assert_rsp_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |=> rsp_valid);

   assert_rsp_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_req |=> !rsp_valid);
endmodule

// File: rtl/mm_doorbell_bank.sv
module mm_doorbell_bank
   import mm_doorbell_pkg::*;
#(
   parameter int NUM_DB      = 4,
   parameter int NUM_MASTERS = 32,
   parameter int NUM_PORTS   = 2,
   parameter int ADDR_W      = 12,
   parameter int MID_W       = 6
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NUM_PORTS-1:0]          bus_valid,
   input  logic [NUM_PORTS-1:0]          bus_write,
   input  logic [NUM_PORTS*ADDR_W-1:0]   bus_addr,
   input  logic [NUM_PORTS*WORD_W-1:0]   bus_wdata,
   input  logic [NUM_PORTS*MID_W-1:0]    bus_mid,
   output logic [NUM_PORTS-1:0]          rsp_valid,
   output logic [NUM_PORTS*WORD_W-1:0]   rsp_rdata,
   output logic [NUM_DB-1:0]             db_irq
);
   localparam int IDX_W = ADDR_W - 8;

   if (NUM_MASTERS < 1 || NUM_MASTERS > WORD_W) begin : g_bad_masters
      $error("NUM_MASTERS must be 1..32");
   end
   if (NUM_DB < 1 || NUM_DB > (1 << IDX_W)) begin : g_bad_db
      $error("NUM_DB does not fit the address width");
   end
   if (NUM_PORTS < 1) begin : g_bad_ports
      $error("NUM_PORTS must be at least 1");
   end
   if ((1 << MID_W) < NUM_MASTERS) begin : g_bad_mid
      $error("MID_W too narrow for NUM_MASTERS");
   end

   logic [NUM_PORTS-1:0][NUM_DB-1:0]      p_hit;
   db_reg_e                               p_sel [NUM_PORTS];
   logic [NUM_PORTS-1:0]                  p_rd;
   logic [NUM_PORTS-1:0][NUM_MASTERS-1:0] p_ring;

   logic [NUM_DB-1:0][NUM_MASTERS-1:0]    c_ring, c_allow_wd, c_seen_clr, c_pend_clr;
   logic [NUM_DB-1:0]                     c_allow_we;
   logic [NUM_DB-1:0][NUM_MASTERS-1:0]    allow_all, seen_all, pend_all;

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      db_port_decode #(
         .NUM_DB(NUM_DB), .NUM_MASTERS(NUM_MASTERS), .ADDR_W(ADDR_W), .MID_W(MID_W)
      ) u_dec (
         .req_valid    (bus_valid[p]),
         .req_write    (bus_write[p]),
         .req_addr     (bus_addr[p*ADDR_W +: ADDR_W]),
         .req_ring_bit (bus_wdata[p*WORD_W]),
         .req_mid      (bus_mid[p*MID_W +: MID_W]),
         .win_hit      (p_hit[p]),
         .reg_sel      (p_sel[p]),
         .is_rd        (p_rd[p]),
         .ring_oh      (p_ring[p])
      );

      db_port_read #(
         .NUM_DB(NUM_DB), .NUM_MASTERS(NUM_MASTERS)
      ) u_rd (
         .clk       (clk),
         .rst_n     (rst_n),
         .rd_req    (p_rd[p]),
         .win_hit   (p_hit[p]),
         .reg_sel   (p_sel[p]),
         .allow_all (allow_all),
         .seen_all  (seen_all),
         .pend_all  (pend_all),
         .rsp_valid (rsp_valid[p]),
         .rsp_rdata (rsp_rdata[p*WORD_W +: WORD_W])
      );
   end

   // Merge all ports into per-doorbell update vectors; later ports win enable writes.
   always_comb begin
      c_ring     = '0;
      c_allow_wd = '0;
      c_seen_clr = '0;
      c_pend_clr = '0;
      c_allow_we = '0;
      for (int d = 0; d < NUM_DB; d++) begin
         for (int p = 0; p < NUM_PORTS; p++) begin
            if (p_hit[p][d] && bus_write[p]) begin
               unique case (p_sel[p])
                  REG_RING:  c_ring[d] = c_ring[d] | p_ring[p];
                  REG_ALLOW: begin
                     c_allow_we[d] = 1'b1;
                     c_allow_wd[d] = bus_wdata[p*WORD_W +: NUM_MASTERS];
                  end
                  REG_SEEN:  c_seen_clr[d] = c_seen_clr[d] | bus_wdata[p*WORD_W +: NUM_MASTERS];
                  default:   c_pend_clr[d] = c_pend_clr[d] | bus_wdata[p*WORD_W +: NUM_MASTERS];
               endcase
            end
         end
      end
   end

   for (genvar d = 0; d < NUM_DB; d++) begin : g_db
      db_cell #(.NUM_MASTERS(NUM_MASTERS)) u_cell (
         .clk         (clk),
         .rst_n       (rst_n),
         .ring_set    (c_ring[d]),
         .allow_we    (c_allow_we[d]),
         .allow_wdata (c_allow_wd[d]),
         .seen_clr    (c_seen_clr[d]),
         .pend_clr    (c_pend_clr[d]),
         .allow_q     (allow_all[d]),
         .seen_q      (seen_all[d]),
         .pend_q      (pend_all[d])
      );

      assign db_irq[d] = |pend_all[d];

      assert_irq_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(db_irq[d]) |-> $past(|(c_ring[d] & allow_all[d])));
   end
endmodule

// File: tb/mm_doorbell_bank_tb_top.sv
`timescale 1ns/1ps
module mm_doorbell_bank_tb_top;
   localparam int NDB = 4, NM = 32, NP = 2, AW = 12, MW = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NP-1:0]    bus_valid = '0;
   logic [NP-1:0]    bus_write = '0;
   logic [NP*AW-1:0] bus_addr  = '0;
   logic [NP*32-1:0] bus_wdata = '0;
   logic [NP*MW-1:0] bus_mid   = '0;
   logic [NP-1:0]    rsp_valid;
   logic [NP*32-1:0] rsp_rdata;
   logic [NDB-1:0]   db_irq;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   mm_doorbell_bank #(.NUM_DB(NDB), .NUM_MASTERS(NM), .NUM_PORTS(NP),
                      .ADDR_W(AW), .MID_W(MW)) dut_i (.*);

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic put(input int p, input logic wr, input logic [AW-1:0] a,
                      input logic [31:0] d, input logic [MW-1:0] m);
      bus_valid[p] = 1'b1;
      bus_write[p] = wr;
      bus_addr[p*AW +: AW] = a;
      bus_wdata[p*32 +: 32] = d;
      bus_mid[p*MW +: MW] = m;
   endtask

   task automatic wr(input int p, input logic [AW-1:0] a, input logic [31:0] d,
                     input logic [MW-1:0] m);
      @(negedge clk);
      put(p, 1'b1, a, d, m);
      @(negedge clk);
      bus_valid = '0;
   endtask

   task automatic rd(input int p, input logic [AW-1:0] a, output logic [31:0] d);
      @(negedge clk);
      put(p, 1'b0, a, 32'h0, '0);
      @(negedge clk);
      bus_valid = '0;
      d = rsp_rdata[p*32 +: 32];
   endtask

   function automatic logic [AW-1:0] ad(input int db, input int off);
      return AW'(db * 256 + off);
   endfunction

   task automatic t_reset();
      logic [31:0] v;
      chk("R11 irq after reset", 32'(db_irq), 32'h0);
      chk("R11 rsp_valid after reset", 32'(rsp_valid), 32'h0);
      rd(0, ad(0, 'hC), v); chk("R11 pending after reset", v, 32'h0);
      rd(1, ad(2, 'h4), v); chk("R11 enable after reset", v, 32'h0);
   endtask

   task automatic t_enable();
      logic [31:0] v;
      wr(0, ad(1, 4), 32'hA5A5_0F0F, 0);
      rd(0, ad(1, 4), v); chk("R4 enable readback", v, 32'hA5A5_0F0F);
      wr(1, ad(0, 4), 32'h0000_0088, 0);
      rd(1, ad(0, 4), v); chk("R4 enable readback db0", v, 32'h88);
      @(negedge clk);
      put(0, 1'b1, ad(1, 4), 32'h1111_1111, 0);
      put(1, 1'b1, ad(1, 4), 32'h2222_2222, 0);
      @(negedge clk); bus_valid = '0;
      rd(0, ad(1, 4), v); chk("R4 higher port wins", v, 32'h2222_2222);
   endtask

   task automatic t_ring();
      logic [31:0] v;
      wr(0, ad(0, 0), 32'h1, 5);
      rd(0, ad(0, 8), v); chk("R2 raw from disabled master", v, 32'h20);
      rd(0, ad(0, 'hC), v); chk("R3 disabled ring not pending", v, 32'h0);
      chk("R9 irq low with no pending", 32'(db_irq), 32'h0);
      wr(1, ad(0, 0), 32'h1, 3);
      chk("R9 irq rises on pending", 32'(db_irq), 32'h1);
      rd(0, ad(0, 'hC), v); chk("R3 enabled ring pending", v, 32'h08);
      rd(0, ad(0, 8), v); chk("R2 raw accumulates", v, 32'h28);
   endtask

   task automatic t_clear();
      logic [31:0] v;
      wr(0, ad(0, 'hC), 32'h0, 0);
      rd(0, ad(0, 'hC), v); chk("R5 zero write keeps pending", v, 32'h08);
      wr(0, ad(0, 'hC), 32'h08, 0);
      rd(0, ad(0, 'hC), v); chk("R5 w1c clears pending", v, 32'h0);
      chk("R9 irq falls after clear", 32'(db_irq), 32'h0);
      wr(1, ad(0, 8), 32'h20, 0);
      rd(1, ad(0, 8), v); chk("R6 raw w1c", v, 32'h08);
   endtask

   task automatic t_noeffect();
      logic [31:0] v;
      wr(0, ad(0, 0), 32'h2, 7);
      rd(0, ad(0, 8), v); chk("R8 zero trigger raw unchanged", v, 32'h08);
      rd(0, ad(0, 'hC), v); chk("R8 zero trigger pending unchanged", v, 32'h0);
      wr(0, ad(0, 0), 32'h1, 6'd40);
      rd(0, ad(0, 8), v); chk("R8 bad master ignored", v, 32'h08);
      chk("R8 irq stays low", 32'(db_irq), 32'h0);
   endtask

   task automatic t_collide();
      logic [31:0] v;
      wr(0, ad(0, 0), 32'h1, 7);
      rd(0, ad(0, 'hC), v); chk("R3 pending bit 7", v, 32'h80);
      @(negedge clk);
      put(0, 1'b1, ad(0, 0), 32'h1, 3);
      put(1, 1'b1, ad(0, 'hC), 32'h88, 0);
      @(negedge clk); bus_valid = '0;
      rd(0, ad(0, 'hC), v); chk("R7 ring beats clear", v, 32'h08);
      wr(1, ad(0, 'hC), 32'h08, 0);
   endtask

   task automatic t_decode();
      logic [31:0] v;
      wr(0, ad(5, 4), 32'hFFFF_FFFF, 0);
      rd(0, ad(5, 4), v); chk("R1 window above NUM_DB reads 0", v, 32'h0);
      wr(0, ad(2, 'h14), 32'hFFFF_FFFF, 0);
      rd(0, ad(2, 4), v); chk("R1 bad offset ignored", v, 32'h0);
      wr(0, ad(2, 0), 32'h1, 0);
      rd(0, ad(2, 8), v); chk("R1 ring reaches db2 only", v, 32'h1);
      rd(0, ad(1, 8), v); chk("R1 db1 untouched", v, 32'h0);
      wr(1, ad(3, 4), 32'h4, 0);
      wr(0, ad(3, 0), 32'h1, 2);
      chk("R9 only db3 interrupts", 32'(db_irq), 32'h8);
   endtask

   task automatic t_read();
      logic [31:0] v;
      rd(1, ad(3, 0), v); chk("R10 trigger reads zero", v, 32'h0);
      chk("R10 rsp_valid one cycle later", 32'(rsp_valid), 32'h2);
      @(negedge clk);
      chk("R10 rsp_valid drops", 32'(rsp_valid), 32'h0);
      rd(1, ad(3, 'hC), v); chk("R10 pending via port 1", v, 32'h4);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_enable();
      t_ring();
      t_clear();
      t_noeffect();
      t_collide();
      t_decode();
      t_read();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule